// File: doc/BRIEF.md
# Configurable Output Logic Macrocell Stage

This block is the output stage of a sum-of-products programmable logic fabric. Each of its cells takes the OR-sum formed for it by the product-term array, an output-enable term and the present level of its bidirectional pin. It then drives that pin and returns one feedback bit to the array. A two-bit mode code per cell chooses between a clocked path and a straight-through path, and between true and inverted output polarity. The mode also decides what the cell feeds back to the array.

All cells share one clock, one asynchronous clear term and one synchronous set term. The clear empties every cell register at once, without waiting for a clock. The set loads every register with 1 at the next rising clock edge. An active-low reset input, pulsed once before the first clock edge, puts every register in the cleared state at power-up. The pin itself is modelled as three signals: a driven value, a drive enable and the sensed pin level. The tristate buffer sits outside the block.

Top module: `olmc_stage`

## Requirements
- R1: Mode bit 1 of a cell selects combinational (1) or registered (0) operation, and mode bit 0 selects active-high (1) or active-low (0). The cell's mode field sits at bits [2i+1:2i] of `mode_i`, so 00 is registered active-low, 01 registered active-high, 10 combinational active-low and 11 combinational active-high.
- R2: In registered mode, the register loads the cell's sum at each rising clock edge. `pad_o` shows the register value unchanged when active-high and inverted when active-low.
- R3: In registered mode, `fb_o` carries the register value without inversion, whatever the polarity, the output enable or the pin level.
- R4: In combinational mode, `pad_o` equals the sum (active-high) or its complement (active-low) in the same cycle, with no clock edge needed.
- R5: In combinational mode, `fb_o` carries the pin level. That is `pad_o` while the output enable is 1, and `pad_i` while it is 0.
- R6: `pad_oe_o` of each cell follows that cell's output-enable term in the same cycle.
- R7: While `areset_i` is 1, every register is 0, and it clears at once without a clock edge.
- R8: When `spreset_i` is 1 at a rising clock edge and `areset_i` is 0, every register becomes 1 regardless of its sum.
- R9: When `areset_i` and `spreset_i` are both 1, the registers are 0.
- R10: After `rst_ni` has been low, every register is 0. A registered active-low cell then drives `pad_o` = 1 and a registered active-high cell drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared register clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| areset_i | input | 1 | Shared asynchronous clear term |
| spreset_i | input | 1 | Shared synchronous set term |
| mode_i | input | 2*NUM_CELLS | Per-cell mode code, two bits per cell |
| sum_i | input | NUM_CELLS | Per-cell OR-sum from the product-term array |
| oe_term_i | input | NUM_CELLS | Per-cell output-enable term |
| pad_i | input | NUM_CELLS | Sensed pin level of each cell |
| pad_o | output | NUM_CELLS | Value each cell drives onto its pin |
| pad_oe_o | output | NUM_CELLS | Pin drive enable of each cell |
| fb_o | output | NUM_CELLS | Feedback of each cell to the array |

## Verification
A wrong register value in a registered cell shows on `fb_o` and, after the polarity inverter, on `pad_o` in the same cycle the register holds it. It is therefore caught at the first sample after the faulty edge. A wrong feedback source appears only when the output enable is off and the sensed pin differs from the driven value, so those cases are driven on purpose. A cell in combinational mode hides its register. The same stimulus is therefore applied with mixed modes, so each cell's register is seen in some cell of the stage.

// File: rtl/olmc_pkg.sv
package olmc_pkg;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned MODE_COMB_BIT = 1;
  localparam int unsigned MODE_HIGH_BIT = 0;

  typedef enum logic [MODE_W-1:0] {
    MODE_REG_LO  = 2'b00,
    MODE_REG_HI  = 2'b01,
    MODE_COMB_LO = 2'b10,
    MODE_COMB_HI = 2'b11
  } olmc_mode_e;
endpackage

// File: rtl/olmc_state_reg.sv
module olmc_state_reg (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic preset_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni)       q_o <= 1'b0;
    else if (preset_i) q_o <= 1'b1;
    else               q_o <= d_i;
  end
endmodule

// File: rtl/olmc_out_sel.sv
module olmc_out_sel
  import olmc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sum_i,
  input  logic              q_i,
  input  logic              oe_i,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              fb_o
);
  logic comb_sel;
  logic high_sel;
  logic src;
  logic pin_lvl;

  assign comb_sel = mode_i[MODE_COMB_BIT];
  assign high_sel = mode_i[MODE_HIGH_BIT];

  always_comb begin
    src      = comb_sel ? sum_i : q_i;
    pad_o    = high_sel ? src : ~src;
    pad_oe_o = oe_i;
    // pin level: own drive when enabled, external value otherwise
    pin_lvl  = oe_i ? pad_o : pad_i;
    fb_o     = comb_sel ? pin_lvl : q_i;
  end
endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
  import olmc_pkg::*;
(
  input  logic              clk_i,
  input  logic              clr_ni,
  input  logic              preset_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sum_i,
  input  logic              oe_i,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              fb_o
);
  logic q;

  olmc_state_reg u_reg (
    .clk_i    (clk_i),
    .clr_ni   (clr_ni),
    .preset_i (preset_i),
    .d_i      (sum_i),
    .q_o      (q)
  );

  olmc_out_sel u_sel (
    .mode_i   (mode_i),
    .sum_i    (sum_i),
    .q_i      (q),
    .oe_i     (oe_i),
    .pad_i    (pad_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o),
    .fb_o     (fb_o)
  );
endmodule

// File: rtl/olmc_stage.sv
module olmc_stage
  import olmc_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 10,
  localparam int unsigned MODES_W = NUM_CELLS * MODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 areset_i,
  input  logic                 spreset_i,
  input  logic [MODES_W-1:0]   mode_i,
  input  logic [NUM_CELLS-1:0] sum_i,
  input  logic [NUM_CELLS-1:0] oe_term_i,
  input  logic [NUM_CELLS-1:0] pad_i,
  output logic [NUM_CELLS-1:0] pad_o,
  output logic [NUM_CELLS-1:0] pad_oe_o,
  output logic [NUM_CELLS-1:0] fb_o
);
  // clear dominates preset: it acts asynchronously on every register
  logic clr_n;
  assign clr_n = rst_ni & ~areset_i;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    olmc_cell u_cell (
      .clk_i    (clk_i),
      .clr_ni   (clr_n),
      .preset_i (spreset_i),
      .mode_i   (mode_i[i*MODE_W +: MODE_W]),
      .sum_i    (sum_i[i]),
      .oe_i     (oe_term_i[i]),
      .pad_i    (pad_i[i]),
      .pad_o    (pad_o[i]),
      .pad_oe_o (pad_oe_o[i]),
      .fb_o     (fb_o[i])
    );
  end
endmodule

// File: rtl/olmc_stage_chk.sv
module olmc_stage_chk
  import olmc_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 10,
  localparam int unsigned MODES_W = NUM_CELLS * MODE_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 areset_i,
  input logic                 spreset_i,
  input logic [MODES_W-1:0]   mode_i,
  input logic [NUM_CELLS-1:0] sum_i,
  input logic [NUM_CELLS-1:0] oe_term_i,
  input logic [NUM_CELLS-1:0] pad_i,
  input logic [NUM_CELLS-1:0] pad_o,
  input logic [NUM_CELLS-1:0] pad_oe_o,
  input logic [NUM_CELLS-1:0] fb_o
);
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
    logic comb_m;
    logic high_m;
    assign comb_m = mode_i[i*MODE_W + MODE_COMB_BIT];
    assign high_m = mode_i[i*MODE_W + MODE_HIGH_BIT];

    a_r2_reg_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !comb_m |-> (pad_o[i] == (high_m ? fb_o[i] : !fb_o[i])));

    a_r3_reg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!comb_m && !areset_i && !spreset_i) |=>
        (areset_i || comb_m || fb_o[i] == $past(sum_i[i])));

    a_r4_comb_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
      comb_m |-> (pad_o[i] == (high_m ? sum_i[i] : !sum_i[i])));

    a_r5_comb_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      comb_m |-> (fb_o[i] == (oe_term_i[i] ? pad_o[i] : pad_i[i])));

    a_r6_oe_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_oe_o[i] == oe_term_i[i]);

    a_r7_clear_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (areset_i && !comb_m) |-> !fb_o[i]);

    a_r8_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spreset_i && !areset_i && !comb_m) |=> (areset_i || comb_m || fb_o[i]));

    a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (areset_i && spreset_i && !comb_m) |=> (comb_m || !areset_i || !fb_o[i]));
  end
endmodule

bind olmc_stage olmc_stage_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (.*);

// File: tb/olmc_stage_test.sv
module olmc_stage_test;
  localparam int N = 10;
  localparam int MW = 2 * N;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          areset_i = 1'b0;
  logic          spreset_i = 1'b0;
  logic [MW-1:0] mode_i = '0;
  logic [N-1:0]  sum_i = '0;
  logic [N-1:0]  oe_term_i = '0;
  logic [N-1:0]  pad_i = '0;
  logic [N-1:0]  pad_o;
  logic [N-1:0]  pad_oe_o;
  logic [N-1:0]  fb_o;

  olmc_stage #(.NUM_CELLS(N)) uut (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    string      tag;
    logic [N-1:0] pad;
    logic [N-1:0] oe;
    logic [N-1:0] fb;
  } exp_t;

  exp_t        sb_q[$];
  logic [N-1:0] q_model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic void model_out(input logic [N-1:0] q, output logic [N-1:0] pd,
                                    output logic [N-1:0] fb);
    for (int i = 0; i < N; i++) begin
      logic src, o;
      src = mode_i[2*i+1] ? sum_i[i] : q[i];
      o   = mode_i[2*i] ? src : ~src;
      pd[i] = o;
      fb[i] = mode_i[2*i+1] ? (oe_term_i[i] ? o : pad_i[i]) : q[i];
    end
  endfunction

  function automatic void cmp(input string tag, input logic [N-1:0] ep, input logic [N-1:0] eo,
                              input logic [N-1:0] ef);
    checks++;
    if (pad_o !== ep || pad_oe_o !== eo || fb_o !== ef) begin
      errors++;
      $display("FAIL %s pad=%b/%b oe=%b/%b fb=%b/%b (actual/expected)",
               tag, pad_o, ep, pad_oe_o, eo, fb_o, ef);
    end
  endfunction

  // driver: apply at negedge, push what the next sample must show
  task automatic step(input string tag, input logic [MW-1:0] m, input logic [N-1:0] s,
                      input logic [N-1:0] oe, input logic [N-1:0] pd,
                      input logic ar, input logic sp);
    exp_t e;
    @(negedge clk_i);
    mode_i = m; sum_i = s; oe_term_i = oe; pad_i = pd;
    areset_i = ar; spreset_i = sp;
    if (ar)      q_model = '0;
    else if (sp) q_model = '1;
    else         q_model = s;
    e.tag = tag;
    e.oe  = oe;
    model_out(q_model, e.pad, e.fb);
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.tag, e.pad, e.oe, e.fb);
      end
    end
  end

  function automatic logic [MW-1:0] mode_all(input logic [1:0] m);
    logic [MW-1:0] r;
    for (int i = 0; i < N; i++) r[2*i +: 2] = m;
    return r;
  endfunction

  logic [MW-1:0] mixed;

  initial begin
    logic [N-1:0] ep, ef;
    for (int i = 0; i < N; i++) mixed[2*i +: 2] = 2'(i % 4);
    // R10: reset before any edge, all registered; even cells active-low
    mode_i = mode_all(2'b00);
    for (int i = 0; i < N; i += 2) mode_i[2*i] = 1'b0;
    for (int i = 1; i < N; i += 2) mode_i[2*i] = 1'b1;
    oe_term_i = '1;
    #1;
    q_model = '0;
    model_out(q_model, ep, ef);
    cmp("R10 reset state", ep, oe_term_i, ef);
    #2 rst_ni = 1'b1;
    @(posedge clk_i);

    // R1 R2: registered, both polarities
    step("R2 reg hi load", mode_all(2'b01), 10'b1011001110, '1, '0, 0, 0);
    step("R2 reg hi load 2", mode_all(2'b01), 10'b0100110001, '1, '0, 0, 0);
    step("R1 reg lo inverts", mode_all(2'b00), 10'b1110000111, '1, '0, 0, 0);
    // R3: registered feedback ignores oe, pin level, polarity
    step("R3 reg fb oe off", mode_all(2'b00), 10'b0011110000, '0, 10'b1100110011, 0, 0);
    step("R3 reg fb hi oe off", mode_all(2'b01), 10'b1010101010, 10'b0110011001, '1, 0, 0);
    // R4 R5: combinational
    step("R4 comb hi", mode_all(2'b11), 10'b1001011010, '1, '0, 0, 0);
    step("R4 comb lo", mode_all(2'b10), 10'b1001011010, '1, '1, 0, 0);
    step("R5 comb fb pin in", mode_all(2'b11), 10'b1111100000, '0, 10'b0101010101, 0, 0);
    step("R5 comb fb mixed oe", mode_all(2'b10), 10'b0000011111, 10'b1100110011,
         10'b1010010110, 0, 0);
    // R1 R6: mixed modes per cell
    step("R1 R6 mixed modes", mixed, 10'b0110100101, 10'b1011011011, 10'b0100100100, 0, 0);
    step("R1 mixed modes 2", mixed, 10'b1001011010, '1, '0, 0, 0);
    // R8: preset overrides sum
    step("R8 preset", mode_all(2'b01), '0, '1, '0, 0, 1);
    step("R8 preset lo", mode_all(2'b00), '0, '1, '0, 0, 1);
    // R7: clear without a clock edge
    step("R7 pre load", mode_all(2'b01), '1, '1, '0, 0, 0);
    @(negedge clk_i);
    areset_i = 1'b1;
    #0.5;
    checks++;
    if (fb_o !== '0 || pad_o !== '0) begin
      errors++;
      $display("FAIL R7 async clear fb=%b pad=%b expected 0", fb_o, pad_o);
    end
    @(posedge clk_i);
    #1;
    checks++;
    if (fb_o !== '0) begin
      errors++;
      $display("FAIL R7 held clear fb=%b expected 0", fb_o);
    end
    // R9: clear beats preset
    step("R9 clear beats preset", mode_all(2'b00), '1, '1, '0, 1, 1);
    step("R9 clear beats preset mixed", mixed, '1, '1, '0, 1, 1);
    step("R2 reload after clear", mode_all(2'b01), 10'b1100101011, '1, '0, 0, 0);
    // R10: reset mid-run, registered
    @(negedge clk_i);
    rst_ni = 1'b0;
    mode_i = mixed;
    #0.5;
    q_model = '0;
    model_out(q_model, ep, ef);
    cmp("R10 reset mid-run", ep, oe_term_i, ef);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step("R2 after reset", mixed, 10'b0011001100, '1, 10'b1111100000, 0, 0);
    while (sb_q.size() > 0) @(posedge clk_i);
    @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule